// File: doc/BRIEF.md
# Reboot Command Word Sequencer

This block drives the write side of an FPGA configuration access port. When user logic pulses a trigger, it writes a fixed, ordered series of 32-bit words into the port, one word per clock cycle. The series opens the port, loads the warm-boot registers with the primary and fallback image addresses and the flash read opcode, and issues the reprogram command. It finishes with no-op pad words so that the configuration logic can complete the command.

The two 24-bit image addresses and the 8-bit opcode are captured on the cycle the trigger is accepted, so upstream logic may change them once the stream has started. While the stream runs, the block raises a busy flag, and further trigger pulses are dropped. Debouncing the trigger and whatever the configuration logic does after the reboot are handled elsewhere.

Top module: `reboot_seq`

## Requirements
- R1: After a synchronous reset, `cfg_we` is 0, `cfg_cs_n` is 1, `seq_busy` is 0 and `cfg_data` is 0.
- R2: A trigger that is sampled high while idle starts a stream. The first word, 0xFFFFFFFF, is on `cfg_data` during the clock cycle that follows that edge.
- R3: The second word is the synchronisation pattern 0xAA995566.
- R4: The third word is {16'h3261, primary[15:0]}. The fourth word is {16'h3281, opcode[7:0], primary[23:16]}.
- R5: The fifth word is {16'h32A1, fallback[15:0]}. The sixth word is {16'h32C1, opcode[7:0], fallback[23:16]}.
- R6: The seventh word is the reprogram command write 0x30A1000E.
- R7: After the command come PAD_WORDS (default 2) words of 0x20002000. The block is idle in the cycle after the last pad word.
- R8: `cfg_we` = 1, `cfg_cs_n` = 0 and `seq_busy` = 1 hold for exactly the 7+PAD_WORDS stream cycles. In every other cycle they are 0, 1 and 0, and `cfg_data` is 0.
- R9: A trigger sampled while busy has no effect. This includes the edge that ends the stream. The stream keeps its content and length.
- R10: Address and opcode inputs are sampled only at the accepting edge. Changing them during a stream does not alter the words still to come.
- R11: A trigger held high across the end of a stream starts a new stream one idle cycle after the previous one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_trig | input | 1 | Request to start the reboot stream |
| primary_addr | input | 24 | Flash byte address of the upgradable image |
| fallback_addr | input | 24 | Flash byte address of the fallback image |
| flash_rd_op | input | 8 | Flash read opcode placed in the high-address words (0x03 for single-lane read) |
| cfg_data | output | 32 | Word written to the configuration port |
| cfg_we | output | 1 | Write enable, high for each stream word |
| cfg_cs_n | output | 1 | Active-low port select |
| seq_busy | output | 1 | High while the stream is being emitted |

## Verification
The hardest situation to reach is a trigger that arrives on the boundary between two streams. It may be sampled on the edge that retires the last pad word, when busy is still high, or on the edge after that, when the block is already idle. The bench holds the trigger high from the last word into the idle cycle and checks two things: one idle cycle appears, and a fresh stream begins with the captured addresses. Other streams scramble the trigger and every address input on each word to show that the remaining words are unaffected.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int ADDR_W = 24;
    localparam int OP_W   = 8;
    localparam int WORD_W = 32;
    localparam int HDR_WORDS = 7;

    localparam logic [WORD_W-1:0] W_DUMMY  = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] W_SYNC   = 32'hAA99_5566;
    localparam logic [15:0]       H_PRI_LO = 16'h3261;
    localparam logic [15:0]       H_PRI_HI = 16'h3281;
    localparam logic [15:0]       H_FB_LO  = 16'h32A1;
    localparam logic [15:0]       H_FB_HI  = 16'h32C1;
    localparam logic [WORD_W-1:0] W_REBOOT = 32'h30A1_000E;
    localparam logic [WORD_W-1:0] W_NOOP   = 32'h2000_2000;

    typedef struct packed {
        logic [ADDR_W-1:0] pri;
        logic [ADDR_W-1:0] fb;
        logic [OP_W-1:0]   op;
    } boot_cfg_t;

    typedef enum logic [2:0] {
        SLOT_DUMMY  = 3'd0,
        SLOT_SYNC   = 3'd1,
        SLOT_PRI_LO = 3'd2,
        SLOT_PRI_HI = 3'd3,
        SLOT_FB_LO  = 3'd4,
        SLOT_FB_HI  = 3'd5,
        SLOT_REBOOT = 3'd6,
        SLOT_PAD    = 3'd7
    } slot_e;

    function automatic slot_e slot_of(input int unsigned k);
        if (k >= HDR_WORDS) return SLOT_PAD;
        return slot_e'(k[2:0]);
    endfunction

    function automatic logic [WORD_W-1:0] word_for(input slot_e s, input boot_cfg_t c);
        case (s)
            SLOT_DUMMY:  return W_DUMMY;
            SLOT_SYNC:   return W_SYNC;
            SLOT_PRI_LO: return {H_PRI_LO, c.pri[15:0]};
            SLOT_PRI_HI: return {H_PRI_HI, c.op, c.pri[23:16]};
            SLOT_FB_LO:  return {H_FB_LO, c.fb[15:0]};
            SLOT_FB_HI:  return {H_FB_HI, c.op, c.fb[23:16]};
            SLOT_REBOOT: return W_REBOOT;
            default:     return W_NOOP;
        endcase
    endfunction

endpackage

// File: rtl/rbs_ctrl.sv
module rbs_ctrl #(
    parameter int TOTAL = 9,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             start,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    assign start = trig & ~active;
    assign last  = active & (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (active && !last) |=> (active && idx == $past(idx) + 1'b1)); // R7
    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        last |=> !active); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (active && !last && trig) |=> (idx != '0)); // R9
    AST_START: assert property (@(posedge clk) disable iff (rst)
        (trig && !active) |=> (active && idx == '0)); // R2

endmodule

// File: rtl/rbs_capture.sv
module rbs_capture
    import rbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              active,
    input  boot_cfg_t         cfg_in,
    output boot_cfg_t         cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)       cfg_q <= '0;
        else if (load) cfg_q <= cfg_in;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && !load) |=> $stable(cfg_q)); // R10

endmodule

// File: rtl/rbs_emit.sv
module rbs_emit
    import rbs_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              active,
    input  logic [IDX_W-1:0]  idx,
    input  boot_cfg_t         cfg,
    output logic [WORD_W-1:0] data,
    output logic              we,
    output logic              cs_n
);

    slot_e slot;

    always_comb begin
        slot = slot_of(int'(idx));
        data = active ? word_for(slot, cfg) : '0;
        we   = active;
        cs_n = ~active;
    end

endmodule

// File: rtl/reboot_seq.sv
module reboot_seq
    import rbs_pkg::*;
#(
    parameter int PAD_WORDS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_trig,
    input  logic [23:0]       primary_addr,
    input  logic [23:0]       fallback_addr,
    input  logic [7:0]        flash_rd_op,
    output logic [31:0]       cfg_data,
    output logic              cfg_we,
    output logic              cfg_cs_n,
    output logic              seq_busy
);

    localparam int TOTAL = HDR_WORDS + PAD_WORDS;
    localparam int IDX_W = $clog2(TOTAL);

    logic             active;
    logic [IDX_W-1:0] idx;
    logic             start;
    logic             last;
    boot_cfg_t        cfg_in;
    boot_cfg_t        cfg_q;

    assign cfg_in = '{pri: primary_addr, fb: fallback_addr, op: flash_rd_op};

    rbs_ctrl #(.TOTAL(TOTAL)) ctrl_i (
        .clk(clk), .rst(rst), .trig(boot_trig),
        .active(active), .idx(idx), .start(start), .last(last)
    );

    rbs_capture cap_i (
        .clk(clk), .rst(rst), .load(start), .active(active),
        .cfg_in(cfg_in), .cfg_q(cfg_q)
    );

    rbs_emit #(.IDX_W(IDX_W)) emit_i (
        .active(active), .idx(idx), .cfg(cfg_q),
        .data(cfg_data), .we(cfg_we), .cs_n(cfg_cs_n)
    );

    assign seq_busy = active;

    AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
        cfg_we == !cfg_cs_n); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |-> (cfg_data == '0)); // R8
    AST_FIRST_DUMMY: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_we) |-> (cfg_data == W_DUMMY)); // R2
    AST_SYNC_NEXT: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_we) |=> (cfg_data == W_SYNC)); // R3

endmodule

// File: tb/reboot_seq_tb_top.sv
module reboot_seq_tb_top;

    localparam int PAD   = 2;
    localparam int TOTAL = 7 + PAD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_trig = 1'b0;
    logic [23:0] primary_addr = '0;
    logic [23:0] fallback_addr = '0;
    logic [7:0]  flash_rd_op = '0;
    logic [31:0] cfg_data;
    logic        cfg_we, cfg_cs_n, seq_busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    reboot_seq #(.PAD_WORDS(PAD)) dut_i (
        .clk(clk), .rst(rst), .boot_trig(boot_trig),
        .primary_addr(primary_addr), .fallback_addr(fallback_addr),
        .flash_rd_op(flash_rd_op), .cfg_data(cfg_data), .cfg_we(cfg_we),
        .cfg_cs_n(cfg_cs_n), .seq_busy(seq_busy)
    );

    function automatic logic [31:0] exp_word(int k, logic [23:0] p, logic [23:0] f, logic [7:0] o);
        if (k == 0) return 32'hFFFFFFFF;
        if (k == 1) return 32'hAA995566;
        if (k == 2) return {16'h3261, p[15:0]};
        if (k == 3) return {16'h3281, o, p[23:16]};
        if (k == 4) return {16'h32A1, f[15:0]};
        if (k == 5) return {16'h32C1, o, f[23:16]};
        if (k == 6) return 32'h30A1000E;
        return 32'h20002000;
    endfunction

    function automatic string req_of(int k);
        if (k == 0) return "R2";
        if (k == 1) return "R3";
        if (k < 4)  return "R4";
        if (k < 6)  return "R5";
        if (k == 6) return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(cfg_we == 1'b0 && cfg_cs_n == 1'b1 && seq_busy == 1'b0 && cfg_data == 32'h0,
              req, {cfg_data[28:0], cfg_we, cfg_cs_n, seq_busy}, 32'h2);
    endtask

    // Called at a negedge with the block idle. disturb scrambles inputs and
    // trigger during the stream (R9, R10); chain holds the trigger across the end (R11).
    task automatic run_stream(input logic [23:0] p, input logic [23:0] f, input logic [7:0] o,
                              input bit disturb, input bit chain);
        primary_addr = p; fallback_addr = f; flash_rd_op = o;
        boot_trig = 1'b1;
        @(negedge clk);
        boot_trig = 1'b0;
        for (int k = 0; k < TOTAL; k++) begin
            check(cfg_data == exp_word(k, p, f, o),
                  disturb ? {req_of(k), "/R9/R10"} : req_of(k), cfg_data, exp_word(k, p, f, o));
            check(cfg_we && !cfg_cs_n && seq_busy, "R8",
                  {29'h0, cfg_we, cfg_cs_n, seq_busy}, 32'h5);
            if (disturb) begin
                primary_addr  = 24'($urandom);
                fallback_addr = 24'($urandom);
                flash_rd_op   = 8'($urandom);
                boot_trig     = 1'($urandom);
            end
            if (k == TOTAL - 1) begin
                boot_trig = chain;
                if (chain) begin
                    primary_addr = p; fallback_addr = f; flash_rd_op = o;
                end
            end
            @(negedge clk);
        end
        check_idle(chain ? "R11" : "R7/R8");
        if (chain) begin
            @(negedge clk);
            boot_trig = 1'b0;
            check(seq_busy && cfg_data == 32'hFFFFFFFF, "R11", cfg_data, 32'hFFFFFFFF);
            for (int k = 1; k < TOTAL; k++) begin
                @(negedge clk);
                check(cfg_data == exp_word(k, p, f, o), "R11", cfg_data, exp_word(k, p, f, o));
            end
            @(negedge clk);
            check_idle("R11");
        end
        boot_trig = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check_idle("R1");
        @(negedge clk);
        check_idle("R1");

        // Directed: single-lane read opcode, typical image addresses
        run_stream(24'h000000, 24'h010000, 8'h03, 1'b0, 1'b0);
        @(negedge clk);
        // Directed: address bit extremes
        run_stream(24'hFFFFFF, 24'h000000, 8'h03, 1'b0, 1'b0);
        run_stream(24'h123456, 24'hABCDEF, 8'h6B, 1'b1, 1'b0);
        // Back-to-back trigger held over the final word
        run_stream(24'h0F0F0F, 24'hF0F0F0, 8'h03, 1'b0, 1'b1);

        for (int i = 0; i < 40; i++) begin
            repeat (1 + ($urandom % 3)) @(negedge clk);
            run_stream(24'($urandom), 24'($urandom), 8'($urandom), 1'($urandom), 1'b0);
        end

        // Idle input activity without trigger keeps outputs quiet
        for (int i = 0; i < 5; i++) begin
            primary_addr = 24'($urandom);
            @(negedge clk);
            check_idle("R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule